// File: doc/BRIEF.md
# Shift and Rotate Unit

This block is the single-position shift and rotate stage of a processor datapath that works on byte, word and long operands. From one operand, an operation code, a size code, a step-count select and the current carry flag, it produces the shifted value and a new set of negative, zero, overflow and carry flags in the same cycle. It has no clock and no state, and the value it returns is meant to be written straight back to the register file.

The unit offers eight operations. There are logical and arithmetic shifts in each direction, plain rotates in each direction, and rotates through the carry flag in each direction. A single select bit moves the operand by one or two positions. When two positions are selected, the unit applies two single-position steps one after the other. In the carry rotates, the carry produced by the first step feeds the second step.

Top module: `shr_unit`

## Requirements
- R1: Encodings. `op_sel` codes are 0 logical left, 1 logical right, 2 arithmetic left, 3 arithmetic right, 4 rotate left, 5 rotate right, 6 rotate left through carry and 7 rotate right through carry. `size_sel` codes are 0 byte (8 bits), 1 word (16 bits), 2 long (32 bits), and 3 also selects long. `twice` = 0 moves the operand one position and `twice` = 1 moves it two positions.
- R2: Result bits above the selected size are always zero, and operand bits above the selected size have no effect on any output.
- R3: A logical left shift fills the LSB with zero. C becomes the last bit moved out of the size MSB, and V is 0.
- R4: A logical right shift fills the size MSB with zero. C becomes the last bit moved out of bit 0, and V is 0.
- R5: An arithmetic left shift fills the LSB with zero and sets C to the last bit that leaves the MSB. V is 1 when the sign bit changes on any of the steps taken.
- R6: An arithmetic right shift copies the sign bit into the vacated top position. C becomes the last bit moved out of bit 0, and V is 0.
- R7: A plain rotate left copies the departing MSB into both bit 0 and C. A plain rotate right copies the departing bit 0 into both the MSB and C. V is 0 for both.
- R8: A rotate through carry left moves the incoming C into bit 0, and the departing MSB becomes the new C, once for each step. A rotate through carry right does the same in the other direction. V is 0 for both.
- R9: N equals the result bit at the MSB of the selected size. Z is 1 exactly when the result is zero at that size.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd | input | 32 | Operand to shift or rotate |
| op_sel | input | 3 | Operation code (R1) |
| size_sel | input | 2 | Operand size code (R1) |
| twice | input | 1 | 0: one position, 1: two positions |
| c_in | input | 1 | Current carry flag |
| result | output | 32 | Shifted value, zero above the size |
| n_out | output | 1 | Negative flag |
| z_out | output | 1 | Zero flag |
| v_out | output | 1 | Overflow flag |
| c_out | output | 1 | Carry flag |

## Verification
The bench builds the unit with its default 32-bit long width. At that width all three sizes exist: the byte at one quarter of the word and the word at one half. This makes the masking of the upper bits and the choice of the flag MSB visible for every operation. Random operands are fully random in their upper bits, so the rule that bits above the size are ignored is exercised on every vector. Directed cases cover the following:
- arithmetic left shifts where the sign changes only on the second step;
- carry chaining through both steps of the carry rotates;
- all-zero and all-one operands.

// File: rtl/shr_pkg.sv
package shr_pkg;

  typedef enum logic [2:0] {
    OP_SHLL  = 3'd0,
    OP_SHLR  = 3'd1,
    OP_SHAL  = 3'd2,
    OP_SHAR  = 3'd3,
    OP_ROTL  = 3'd4,
    OP_ROTR  = 3'd5,
    OP_ROTXL = 3'd6,
    OP_ROTXR = 3'd7
  } shift_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_ALT  = 2'd3
  } size_e;

  // Bit 0 of the operation code gives the direction: 1 means toward bit 0.
  function automatic logic op_is_right(input shift_op_e op);
    return op[0];
  endfunction

endpackage

// File: rtl/shr_size_ctl.sv
module shr_size_ctl #(
  parameter int WORD_W = 32,
  localparam int IDX_W = $clog2(WORD_W)
) (
  input  shr_pkg::size_e     size_i,
  output logic [WORD_W-1:0]  mask_o,
  output logic [IDX_W-1:0]   msb_idx_o,
  output logic [IDX_W-1:0]   nxt_idx_o
);
  localparam int BYTE_W = WORD_W / 4;
  localparam int HALF_W = WORD_W / 2;

  always_comb begin
    unique case (size_i)
      shr_pkg::SZ_BYTE: begin
        mask_o    = {{(WORD_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
        msb_idx_o = IDX_W'(BYTE_W - 1);
        nxt_idx_o = IDX_W'(BYTE_W - 2);
      end
      shr_pkg::SZ_WORD: begin
        mask_o    = {{(WORD_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
        msb_idx_o = IDX_W'(HALF_W - 1);
        nxt_idx_o = IDX_W'(HALF_W - 2);
      end
      default: begin
        mask_o    = {WORD_W{1'b1}};
        msb_idx_o = IDX_W'(WORD_W - 1);
        nxt_idx_o = IDX_W'(WORD_W - 2);
      end
    endcase
  end
endmodule

// File: rtl/shr_step.sv
module shr_step #(
  parameter int WORD_W = 32,
  localparam int IDX_W = $clog2(WORD_W)
) (
  input  shr_pkg::shift_op_e op_i,
  input  logic [WORD_W-1:0]  val_i,
  input  logic [WORD_W-1:0]  mask_i,
  input  logic [IDX_W-1:0]   msb_idx_i,
  input  logic [IDX_W-1:0]   nxt_idx_i,
  input  logic               c_i,
  output logic [WORD_W-1:0]  val_o,
  output logic               c_o,
  output logic               sgn_chg_o
);
  logic top_bit;
  logic sub_bit;
  logic low_bit;
  logic fill;

  always_comb begin
    top_bit = val_i[msb_idx_i];
    sub_bit = val_i[nxt_idx_i];
    low_bit = val_i[0];

    unique case (op_i)
      shr_pkg::OP_SHAR:  fill = top_bit;
      shr_pkg::OP_ROTL:  fill = top_bit;
      shr_pkg::OP_ROTR:  fill = low_bit;
      shr_pkg::OP_ROTXL: fill = c_i;
      shr_pkg::OP_ROTXR: fill = c_i;
      default:           fill = 1'b0;
    endcase

    if (shr_pkg::op_is_right(op_i)) begin
      val_o = (val_i >> 1) | ({{(WORD_W-1){1'b0}}, fill} << msb_idx_i);
      c_o   = low_bit;
    end else begin
      val_o = ((val_i << 1) & mask_i) | {{(WORD_W-1){1'b0}}, fill};
      c_o   = top_bit;
    end

    sgn_chg_o = top_bit ^ sub_bit;
  end
endmodule

// File: rtl/shr_flags.sv
module shr_flags #(
  parameter int WORD_W = 32,
  localparam int IDX_W = $clog2(WORD_W)
) (
  input  logic [WORD_W-1:0] res_i,
  input  logic [IDX_W-1:0]  msb_idx_i,
  output logic              n_o,
  output logic              z_o
);
  always_comb begin
    n_o = res_i[msb_idx_i];
    z_o = (res_i == '0);
  end
endmodule

// File: rtl/shr_unit.sv
module shr_unit #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] opnd,
  input  logic [2:0]        op_sel,
  input  logic [1:0]        size_sel,
  input  logic              twice,
  input  logic              c_in,
  output logic [WORD_W-1:0] result,
  output logic              n_out,
  output logic              z_out,
  output logic              v_out,
  output logic              c_out
);
  localparam int IDX_W    = $clog2(WORD_W);
  localparam int STEP_CNT = 2;

  shr_pkg::shift_op_e op;
  shr_pkg::size_e     sz;

  logic [WORD_W-1:0] mask;
  logic [IDX_W-1:0]  msb_idx;
  logic [IDX_W-1:0]  nxt_idx;

  logic [WORD_W-1:0] stage_val [STEP_CNT+1];
  logic              stage_c   [STEP_CNT+1];
  logic              stage_chg [STEP_CNT];

  logic [WORD_W-1:0] sel_val;
  logic              sel_c;
  logic              any_chg;

  assign op = shr_pkg::shift_op_e'(op_sel);
  assign sz = shr_pkg::size_e'(size_sel);

  shr_size_ctl #(.WORD_W(WORD_W)) u_size (
    .size_i    (sz),
    .mask_o    (mask),
    .msb_idx_o (msb_idx),
    .nxt_idx_o (nxt_idx)
  );

  assign stage_val[0] = opnd & mask;
  assign stage_c[0]   = c_in;

  for (genvar k = 0; k < STEP_CNT; k++) begin : g_step
    shr_step #(.WORD_W(WORD_W)) u_step (
      .op_i      (op),
      .val_i     (stage_val[k]),
      .mask_i    (mask),
      .msb_idx_i (msb_idx),
      .nxt_idx_i (nxt_idx),
      .c_i       (stage_c[k]),
      .val_o     (stage_val[k+1]),
      .c_o       (stage_c[k+1]),
      .sgn_chg_o (stage_chg[k])
    );
  end

  always_comb begin
    if (twice) begin
      sel_val = stage_val[2];
      sel_c   = stage_c[2];
      any_chg = stage_chg[0] | stage_chg[1];
    end else begin
      sel_val = stage_val[1];
      sel_c   = stage_c[1];
      any_chg = stage_chg[0];
    end
  end

  assign result = sel_val;
  assign c_out  = sel_c;
  assign v_out  = (op == shr_pkg::OP_SHAL) ? any_chg : 1'b0;

  shr_flags #(.WORD_W(WORD_W)) u_flags (
    .res_i     (sel_val),
    .msb_idx_i (msb_idx),
    .n_o       (n_out),
    .z_o       (z_out)
  );
endmodule

// File: rtl/shr_unit_chk.sv
module shr_unit_chk #(
  parameter int WORD_W = 32
) (
  input logic [WORD_W-1:0] opnd,
  input logic [2:0]        op_sel,
  input logic [1:0]        size_sel,
  input logic              twice,
  input logic              c_in,
  input logic [WORD_W-1:0] result,
  input logic              n_out,
  input logic              z_out,
  input logic              v_out,
  input logic              c_out
);
  localparam int BYTE_W = WORD_W / 4;
  localparam int HALF_W = WORD_W / 2;

  logic top_res;

  always_comb begin
    unique case (size_sel)
      2'd0:    top_res = result[BYTE_W-1];
      2'd1:    top_res = result[HALF_W-1];
      default: top_res = result[WORD_W-1];
    endcase

    if (size_sel == 2'd0)
      AST_BYTE_UPPER_ZERO: assert (result[WORD_W-1:BYTE_W] == '0);   // R2
    if (size_sel == 2'd1)
      AST_WORD_UPPER_ZERO: assert (result[WORD_W-1:HALF_W] == '0);   // R2
    if (op_sel != 3'd2)
      AST_V_ONLY_ARITH_LEFT: assert (!v_out);                        // R3
    AST_ZERO_FLAG: assert (z_out == (result == '0));                 // R9
    AST_NEG_FLAG: assert (n_out == top_res);                         // R9
    if (op_sel == 3'd4)
      AST_ROTL_CARRY_LSB: assert (c_out == result[0]);               // R7
    if (op_sel == 3'd5)
      AST_ROTR_CARRY_MSB: assert (c_out == top_res);                 // R7
    if (op_sel == 3'd6 && !twice)
      AST_ROTXL_CIN_LSB: assert (result[0] == c_in);                 // R8
    if (op_sel == 3'd1)
      AST_SHLR_TOP_ZERO: assert (!top_res);                          // R4
  end

  logic unused_ok;
  assign unused_ok = ^opnd;
endmodule

bind shr_unit shr_unit_chk #(.WORD_W(WORD_W)) u_shr_unit_chk (
  .opnd     (opnd),
  .op_sel   (op_sel),
  .size_sel (size_sel),
  .twice    (twice),
  .c_in     (c_in),
  .result   (result),
  .n_out    (n_out),
  .z_out    (z_out),
  .v_out    (v_out),
  .c_out    (c_out)
);

// File: tb/shr_unit_bench.sv
module shr_unit_bench;
  localparam int W = 32;

  logic clk;
  logic rst_n;
  logic [W-1:0] opnd;
  logic [2:0]   op_sel;
  logic [1:0]   size_sel;
  logic         twice;
  logic         c_in;
  logic [W-1:0] result;
  logic         n_out, z_out, v_out, c_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  shr_unit #(.WORD_W(W)) u_shr_unit (
    .opnd(opnd), .op_sel(op_sel), .size_sel(size_sel), .twice(twice),
    .c_in(c_in), .result(result), .n_out(n_out), .z_out(z_out),
    .v_out(v_out), .c_out(c_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [35:0] ref_model(input logic [31:0] a, input logic [2:0] op,
                                            input logic [1:0] sz, input logic two,
                                            input logic cin);
    int w;
    logic [63:0] x, m;
    logic c, v, hi, lo;
    w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    m = (64'd1 << w) - 64'd1;
    x = {32'd0, a} & m;
    c = cin;
    v = 1'b0;
    for (int s = 0; s < (two ? 2 : 1); s++) begin
      hi = x[w-1];
      lo = x[0];
      case (op)
        3'd0: begin c = hi; x = (x << 1) & m; end
        3'd1: begin c = lo; x = x >> 1; end
        3'd2: begin c = hi; if (x[w-1] != x[w-2]) v = 1'b1; x = (x << 1) & m; end
        3'd3: begin c = lo; x = (x >> 1) | ({63'd0, hi} << (w-1)); end
        3'd4: begin c = hi; x = ((x << 1) & m) | {63'd0, hi}; end
        3'd5: begin c = lo; x = (x >> 1) | ({63'd0, lo} << (w-1)); end
        3'd6: begin x = ((x << 1) & m) | {63'd0, c}; c = hi; end
        default: begin x = (x >> 1) | ({63'd0, c} << (w-1)); c = lo; end
      endcase
    end
    return {x[31:0], x[w-1], (x == 64'd0), v, c};
  endfunction

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4, 3'd5: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic drive(input logic [31:0] a, input logic [2:0] op, input logic [1:0] sz,
                       input logic two, input logic cin);
    @(posedge clk);
    opnd = a; op_sel = op; size_sel = sz; twice = two; c_in = cin;
    @(negedge clk);
  endtask

  task automatic check_vec(input string tag, input logic [35:0] exp);
    logic [35:0] act;
    act = {result, n_out, z_out, v_out, c_out};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s op=%0d sz=%0d two=%0b cin=%0b opnd=%h actual=%h expected=%h",
               tag, op_sel, size_sel, twice, c_in, opnd, act, exp);
    end
  endtask

  task automatic run_ref(input string tag, input logic [31:0] a, input logic [2:0] op,
                         input logic [1:0] sz, input logic two, input logic cin);
    drive(a, op, sz, two, cin);
    check_vec(tag, ref_model(a, op, sz, two, cin));
  endtask

  task automatic run_lit(input string tag, input logic [31:0] a, input logic [2:0] op,
                         input logic [1:0] sz, input logic two, input logic cin,
                         input logic [35:0] exp);
    drive(a, op, sz, two, cin);
    check_vec(tag, exp);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] a;
    logic [2:0] op;
    logic [1:0] sz;
    logic two, cin;
    int seed;
    seed = 32'h5A17;
    a = $urandom(seed);
    rst_n = 1'b0;
    opnd = '0; op_sel = '0; size_sel = '0; twice = 1'b0; c_in = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Idle inputs: zero result with Z set (R9)
    check_vec("R9 idle", {32'd0, 1'b0, 1'b1, 1'b0, 1'b0});

    // R5: sign change only on the second step
    run_lit("R5", 32'h0000_0030, 3'd2, 2'd0, 1'b1, 1'b0, {32'h0000_00C0, 1'b1, 1'b0, 1'b1, 1'b0});
    run_lit("R5", 32'h0000_00C0, 3'd2, 2'd0, 1'b0, 1'b0, {32'h0000_0080, 1'b1, 1'b0, 1'b0, 1'b1});
    run_lit("R5", 32'h0000_4000, 3'd2, 2'd1, 1'b0, 1'b0, {32'h0000_8000, 1'b1, 1'b0, 1'b1, 1'b0});
    // R2: upper bits ignored for a byte
    run_lit("R2", 32'hFFFF_FF00, 3'd0, 2'd0, 1'b0, 1'b1, {32'h0, 1'b0, 1'b1, 1'b0, 1'b0});
    // R6: sign fill for a word
    run_lit("R6", 32'h0001_8001, 3'd3, 2'd1, 1'b1, 1'b0, {32'h0000_E000, 1'b1, 1'b0, 1'b0, 1'b0});
    // R8: carry chains through both steps
    run_lit("R8", 32'h8000_0000, 3'd6, 2'd2, 1'b1, 1'b1, {32'h0000_0003, 1'b0, 1'b0, 1'b0, 1'b0});
    run_lit("R8", 32'h0000_0001, 3'd7, 2'd0, 1'b1, 1'b1, {32'h0000_00C0, 1'b1, 1'b0, 1'b0, 1'b0});
    // R7: rotate of all ones stays all ones
    run_lit("R7", 32'hFFFF_FFFF, 3'd5, 2'd1, 1'b1, 1'b0, {32'h0000_FFFF, 1'b1, 1'b0, 1'b0, 1'b1});
    // R4: logical right fills zero, C from bit 0
    run_lit("R4", 32'h0000_0003, 3'd1, 2'd2, 1'b1, 1'b0, {32'h0, 1'b0, 1'b1, 1'b0, 1'b1});
    // R1: size code 3 behaves as long
    run_lit("R1", 32'h4000_0000, 3'd0, 2'd3, 1'b0, 1'b0, {32'h8000_0000, 1'b1, 1'b0, 1'b0, 1'b0});

    // Exhaustive sweep of controls on corner operands (R1, R9)
    for (int i = 0; i < 64; i++) begin
      run_ref("R1", 32'h8000_8080, 3'(i), 2'(i >> 3), i[5], 1'b1);
      run_ref("R9", 32'h0000_0000, 3'(i), 2'(i >> 3), i[5], i[0]);
    end

    // Constrained random operands (R2 for every vector)
    for (int i = 0; i < 6000; i++) begin
      a = $urandom;
      op = 3'($urandom_range(0, 7));
      sz = 2'($urandom_range(0, 3));
      two = 1'($urandom_range(0, 1));
      cin = 1'($urandom_range(0, 1));
      if ((i % 8) == 0) a = a & 32'h8000_8080;
      run_ref(req_of(op), a, op, sz, two, cin);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule